// File: doc/BRIEF.md
# Predicated Vector Load/Store Sequencer

This block moves one 16-byte vector register to or from memory one element at a time. A start command carries a base address, an element size code, a direction (load or store), a 16-bit lane mask and the current vector contents. The sequencer walks the elements in ascending order. For each element it checks one mask bit. An active element gets one memory transfer on a valid/ready request channel. An inactive element is skipped in a single cycle with no bus activity. In both cases the address moves on by the element size.

Loads wait for the response data of each transfer and write it into the byte lanes that belong to that element. Lanes of skipped elements keep the values captured at start. When the last element has been handled, a one-cycle completion pulse is produced, which the surrounding pipeline can use to advance its predication state. An abort input drops the sequence at once. Lanes already written stay written, and no completion pulse follows.

Top module: `vls_sequencer`

## Requirements
- R1: After reset `busy`, `done` and `memReqValid` are 0 and `vecOut` is all zeros.
- R2: `startSize` code 0, 1, 2 selects 1, 2, 4-byte elements, giving 16, 8, 4 elements. Code 3 behaves exactly like code 2.
- R3: Element e is active when `startMask` bit (e × element bytes) is set. Only active elements produce a request. Every active element produces exactly one request, in ascending element order.
- R4: The request for element e carries address `startAddr` + e × element bytes, modulo 2^32. Skipped elements still take up their address slot.
- R5: `memReqByteEn` is 4'b0001, 4'b0011 or 4'b1111 for 1, 2 or 4-byte elements. On a store, `memReqWData` holds vector bytes e×size … e×size+size−1 in its low bytes (little-endian), and its unused bytes are zero. `memReqWrite` is 1 for stores.
- R6: On a load, the low element-size bytes of `memRspData` replace `vecOut` bytes e×size upward. All other bytes keep the value of `vecIn` captured at start. On a store, `vecOut` equals the captured `vecIn`.
- R7: While `memReqValid` is high and `memReqReady` is low, the request stays asserted with an unchanged address, unless an abort is applied.
- R8: `done` is high for exactly one cycle per completed sequence. That cycle is the first one in which `busy` is low.
- R9: A `startValid` while `busy` is high has no effect on the requests or on the result.
- R10: `abortReq` during a sequence returns the block to idle with no `done`. Bytes loaded before the abort stay in `vecOut`. A response arriving in the same cycle as the abort is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Start a sequence (accepted when idle) |
| startWrite | input | 1 | 1 = store, 0 = load |
| startAddr | input | 32 | Address of element 0 |
| startSize | input | 2 | Element size code (0:1B, 1:2B, 2/3:4B) |
| startMask | input | 16 | Lane mask, one bit per byte lane |
| vecIn | input | 128 | Vector contents captured at start |
| abortReq | input | 1 | Abandon the running sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| vecOut | output | 128 | Working vector (load destination) |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 32 | Request byte address |
| memReqByteEn | output | 4 | Byte enables, low-aligned |
| memReqWData | output | 32 | Store data, low-aligned |
| memRspValid | input | 1 | Load response valid |
| memRspData | input | 32 | Load response data, low-aligned |

## Verification
Two events can land in the same cycle: a load response and an abort. The bench drives the abort in exactly the cycle in which it presents the response for a chosen element. It then expects that element's lanes to keep their old bytes, the earlier elements to hold their loaded data, and no completion pulse to appear. A second collision is a new start raised while a sequence is running. It is judged by the request stream and the final vector, which must match only the first command.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch command and vector
    logic step;       // move to next element, bump address
    logic writeLane;  // merge response bytes into vector
  } dpStrobe_t;

endpackage

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  input  logic      abortReq,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      elemActive,
  input  logic      lastElem,
  input  logic      isWrite,
  output dpStrobe_t strobe,
  output logic      memReqValid,
  output logic      busy,
  output logic      done
);

  seqState_t stateQ, stateD;
  logic      finish;
  logic      doneQ;

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    memReqValid = 1'b0;
    finish      = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (startValid) begin
          strobe.capture = 1'b1;
          stateD         = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        memReqValid = elemActive;
        if (abortReq) begin
          stateD = ST_IDLE;
        end else if (!elemActive) begin
          strobe.step = 1'b1;
          if (lastElem) begin
            finish = 1'b1;
            stateD = ST_IDLE;
          end
        end else if (memReqReady) begin
          if (isWrite) begin
            strobe.step = 1'b1;
            if (lastElem) begin
              finish = 1'b1;
              stateD = ST_IDLE;
            end
          end else begin
            stateD = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (abortReq) begin
          stateD = ST_IDLE;
        end else if (memRspValid) begin
          strobe.writeLane = 1'b1;
          strobe.step      = 1'b1;
          if (lastElem) begin
            finish = 1'b1;
            stateD = ST_IDLE;
          end else begin
            stateD = ST_ISSUE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= finish;
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/vls_datapath.sv
module vls_datapath
  import vls_pkg::*;
#(
  parameter int VEC_BYTES  = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic                      startWrite,
  input  logic [ADDR_W-1:0]         startAddr,
  input  logic [1:0]                startSize,
  input  logic [VEC_BYTES-1:0]      startMask,
  input  logic [VEC_BYTES*8-1:0]    vecIn,
  input  logic [WORD_BYTES*8-1:0]   rspData,
  output logic                      elemActive,
  output logic                      lastElem,
  output logic                      isWrite,
  output logic [ADDR_W-1:0]         reqAddr,
  output logic [WORD_BYTES-1:0]     reqByteEn,
  output logic [WORD_BYTES*8-1:0]   reqWData,
  output logic [VEC_BYTES*8-1:0]    vecOut
);

  localparam int LANE_W   = $clog2(VEC_BYTES);
  localparam int VEC_W    = VEC_BYTES * 8;
  localparam int WORD_W   = WORD_BYTES * 8;
  localparam int SIZE_MAX = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0]    addrQ;
  logic [LANE_W-1:0]    idxQ;
  logic [1:0]           sizeQ;
  logic [VEC_BYTES-1:0] maskQ;
  logic                 writeQ;
  logic [VEC_W-1:0]     vecQ, vecNext;
  logic [1:0]           sizeEff;
  logic [LANE_W-1:0]    laneBase;
  logic [LANE_W:0]      elemCount;
  logic [LANE_W:0]      elemBytes;
  logic [VEC_W-1:0]     vecShift;

  // oversize codes collapse onto the widest element
  assign sizeEff   = (startSize > 2'(SIZE_MAX)) ? 2'(SIZE_MAX) : startSize;

  assign laneBase  = idxQ << sizeQ;
  assign elemCount = (LANE_W+1)'(VEC_BYTES) >> sizeQ;
  assign elemBytes = (LANE_W+1)'(1) << sizeQ;

  assign elemActive = maskQ[laneBase];
  assign lastElem   = ({1'b0, idxQ} == (elemCount - 1'b1));
  assign isWrite    = writeQ;
  assign reqAddr    = addrQ;
  assign vecOut     = vecQ;

  assign vecShift = vecQ >> {laneBase, 3'b000};

  always_comb begin
    for (int j = 0; j < WORD_BYTES; j++) begin
      reqByteEn[j]       = ((LANE_W+1)'(j) < elemBytes);
      reqWData[j*8 +: 8] = reqByteEn[j] ? vecShift[j*8 +: 8] : 8'h00;
    end
  end

  // merge response bytes into the lanes owned by the current element
  always_comb begin
    vecNext = vecQ;
    for (int b = 0; b < VEC_BYTES; b++) begin
      logic [LANE_W-1:0] off;
      logic [WORD_W-1:0] rspShift;
      off      = LANE_W'(b) - laneBase;
      rspShift = rspData >> {off, 3'b000};
      if (strobe.writeLane && ((LANE_W'(b) >> sizeQ) == idxQ)) begin
        vecNext[b*8 +: 8] = rspShift[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      idxQ   <= '0;
      sizeQ  <= '0;
      maskQ  <= '0;
      writeQ <= 1'b0;
      vecQ   <= '0;
    end else if (strobe.capture) begin
      addrQ  <= startAddr;
      idxQ   <= '0;
      sizeQ  <= sizeEff;
      maskQ  <= startMask;
      writeQ <= startWrite;
      vecQ   <= vecIn;
    end else begin
      vecQ <= vecNext;
      if (strobe.step) begin
        idxQ  <= idxQ + 1'b1;
        addrQ <= addrQ + (ADDR_W'(1) << sizeQ);
      end
    end
  end

endmodule

// File: rtl/vls_sequencer.sv
module vls_sequencer
  import vls_pkg::*;
#(
  parameter int VEC_BYTES  = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startValid,
  input  logic                    startWrite,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic [1:0]              startSize,
  input  logic [VEC_BYTES-1:0]    startMask,
  input  logic [VEC_BYTES*8-1:0]  vecIn,
  input  logic                    abortReq,
  output logic                    busy,
  output logic                    done,
  output logic [VEC_BYTES*8-1:0]  vecOut,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic                    memReqWrite,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic [WORD_BYTES-1:0]   memReqByteEn,
  output logic [WORD_BYTES*8-1:0] memReqWData,
  input  logic                    memRspValid,
  input  logic [WORD_BYTES*8-1:0] memRspData
);

  dpStrobe_t strobe;
  logic      elemActive;
  logic      lastElem;
  logic      isWrite;

  vls_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .abortReq   (abortReq),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .elemActive (elemActive),
    .lastElem   (lastElem),
    .isWrite    (isWrite),
    .strobe     (strobe),
    .memReqValid(memReqValid),
    .busy       (busy),
    .done       (done)
  );

  vls_datapath #(
    .VEC_BYTES (VEC_BYTES),
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startWrite(startWrite),
    .startAddr (startAddr),
    .startSize (startSize),
    .startMask (startMask),
    .vecIn     (vecIn),
    .rspData   (memRspData),
    .elemActive(elemActive),
    .lastElem  (lastElem),
    .isWrite   (isWrite),
    .reqAddr   (memReqAddr),
    .reqByteEn (memReqByteEn),
    .reqWData  (memReqWData),
    .vecOut    (vecOut)
  );

  assign memReqWrite = isWrite;

endmodule

// File: rtl/vls_sequencer_chk.sv
module vls_sequencer_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  abortReq,
  input logic                  busy,
  input logic                  done,
  input logic                  memReqValid,
  input logic                  memReqReady,
  input logic [ADDR_W-1:0]     memReqAddr,
  input logic [WORD_BYTES-1:0] memReqByteEn
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R3
  req_in_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady && !abortReq) |=> (memReqValid && $stable(memReqAddr)));

  // R5
  byte_en_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqByteEn == 4'b0001 || memReqByteEn == 4'b0011 ||
                     memReqByteEn == 4'b1111));

endmodule

bind vls_sequencer vls_sequencer_chk #(
  .ADDR_W    (ADDR_W),
  .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .abortReq    (abortReq),
  .busy        (busy),
  .done        (done),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .memReqByteEn(memReqByteEn)
);

// File: tb/vls_sequencer_test.sv
module vls_sequencer_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] addr;
    logic        write;
    logic [3:0]  be;
    logic [31:0] wdata;
  } expReq_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startValid = 1'b0;
  logic         startWrite = 1'b0;
  logic [31:0]  startAddr = '0;
  logic [1:0]   startSize = '0;
  logic [15:0]  startMask = '0;
  logic [127:0] vecIn = '0;
  logic         abortReq = 1'b0;
  logic         busy, done;
  logic [127:0] vecOut;
  logic         memReqValid;
  logic         memReqReady = 1'b1;
  logic         memReqWrite;
  logic [31:0]  memReqAddr;
  logic [3:0]   memReqByteEn;
  logic [31:0]  memReqWData;
  logic         memRspValid = 1'b0;
  logic [31:0]  memRspData = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  expReq_t expQ[$];
  bit  stallMode = 1'b0;
  int  abortAtRsp = -1;
  int  rspCount = 0;
  bit  monitorOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vls_sequencer uut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startWrite(startWrite),
    .startAddr(startAddr), .startSize(startSize), .startMask(startMask),
    .vecIn(vecIn), .abortReq(abortReq), .busy(busy), .done(done),
    .vecOut(vecOut), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqByteEn(memReqByteEn), .memReqWData(memReqWData),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] respWord(input logic [31:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8], a[7:0] + 8'd7, ~a[7:0]};
  endfunction

  // monitor: memory model and scoreboard consumer
  initial begin
    bit      pendingRsp;
    int      readyCnt;
    expReq_t item;
    pendingRsp = 1'b0;
    readyCnt = 0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      abortReq    = 1'b0;
      if (pendingRsp) begin
        memRspValid = 1'b1;
        memRspData  = respWord(memReqAddr);
        if (rspCount == abortAtRsp) abortReq = 1'b1;
        rspCount++;
        pendingRsp = 1'b0;
      end
      readyCnt++;
      memReqReady = !stallMode || ((readyCnt % 3) != 0);
      if (monitorOn && memReqValid && memReqReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected request addr", 128'(memReqAddr), 128'h0);
        end else begin
          item = expQ.pop_front();
          check(memReqAddr == item.addr, "R4", "request address",
                128'(memReqAddr), 128'(item.addr));
          check(memReqWrite == item.write, "R5", "request direction",
                128'(memReqWrite), 128'(item.write));
          check(memReqByteEn == item.be, "R5", "byte enables",
                128'(memReqByteEn), 128'(item.be));
          if (item.write)
            check(memReqWData == item.wdata, "R5", "store data",
                  128'(memReqWData), 128'(item.wdata));
        end
        if (!memReqWrite) pendingRsp = 1'b1;
      end
    end
  end

  // driver: builds expectations, starts the sequence, judges the end state
  task automatic runSeq(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [15:0] mask, input logic [127:0] vin,
                        input bit stall, input bit busyStart, input int abortAt);
    int           bytes, n, k;
    logic [127:0] expVec;
    logic [31:0]  a, w;
    expReq_t      item;
    // R2: code 3 behaves as code 2
    bytes  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    n      = 16 / bytes;
    expVec = vin;
    k      = 0;
    for (int e = 0; e < n; e++) begin
      a = addr + 32'(e * bytes);
      if (mask[e*bytes]) begin
        if (abortAt < 0 || k <= abortAt) begin
          item.addr  = a;
          item.write = wr;
          item.be    = (bytes == 1) ? 4'b0001 : (bytes == 2) ? 4'b0011 : 4'b1111;
          w = '0;
          for (int j = 0; j < bytes; j++) w[j*8 +: 8] = vin[(e*bytes + j)*8 +: 8];
          item.wdata = w;
          expQ.push_back(item);
        end
        if (!wr && (abortAt < 0 || k < abortAt)) begin
          w = respWord(a);
          for (int j = 0; j < bytes; j++) expVec[(e*bytes + j)*8 +: 8] = w[j*8 +: 8];
        end
        k++;
      end
    end
    stallMode  = stall;
    abortAtRsp = abortAt;
    rspCount   = 0;
    @(negedge clk);
    startValid = 1'b1; startWrite = wr; startAddr = addr;
    startSize  = sz;   startMask  = mask; vecIn = vin;
    @(negedge clk);
    startValid = 1'b0;
    vecIn      = ~vin;
    if (busyStart) begin
      @(negedge clk);
      // R9: command raised mid-sequence must leave no trace
      startValid = 1'b1; startWrite = !wr; startAddr = addr ^ 32'h0000_0F00;
      startSize  = 2'd0; startMask  = ~mask;
      @(negedge clk);
      startValid = 1'b0;
    end
    while (busy) @(negedge clk);
    if (abortAt < 0) begin
      check(done == 1'b1, "R8", "done with busy low", 128'(done), 128'h1);
    end else begin
      check(done == 1'b0, "R10", "no done after abort", 128'(done), 128'h0);
    end
    check(vecOut == expVec, (abortAt >= 0) ? "R10" : "R6", "result vector", vecOut, expVec);
    check(expQ.size() == 0, "R3", "missing requests", 128'(expQ.size()), 128'h0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", 128'(done), 128'h0);
    expQ.delete();
    abortAtRsp = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy in reset", 128'(busy), 128'h0);
    check(done == 1'b0, "R1", "done in reset", 128'(done), 128'h0);
    check(memReqValid == 1'b0, "R1", "request in reset", 128'(memReqValid), 128'h0);
    check(vecOut == '0, "R1", "vector in reset", vecOut, 128'h0);
    rstN = 1'b1;
    monitorOn = 1'b1;
    @(negedge clk);

    // R5 R2: byte store, all lanes
    runSeq(1'b1, 2'd0, 32'h0000_1000, 16'hFFFF,
           128'h0F0E0D0C_0B0A0908_07060504_03020100, 1'b0, 1'b0, -1);
    // R3 R4: halfword store, sparse mask, stalls
    runSeq(1'b1, 2'd1, 32'h0000_2002, 16'h5A5A,
           128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D, 1'b1, 1'b0, -1);
    // R6: word load, elements 0,1,3 active, stalls
    runSeq(1'b0, 2'd2, 32'h0000_3000, 16'h1011,
           128'h11112222_33334444_55556666_77778888, 1'b1, 1'b0, -1);
    // R4: byte load across address wrap
    runSeq(1'b0, 2'd0, 32'hFFFF_FFF8, 16'h8001,
           128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF, 1'b0, 1'b0, -1);
    // R2: size code 3 acts as word
    runSeq(1'b0, 2'd3, 32'h0000_4010, 16'hFFFF,
           128'h0, 1'b0, 1'b0, -1);
    // R3 R8: empty mask, no requests but done
    runSeq(1'b0, 2'd1, 32'h0000_5000, 16'h0000,
           128'h55AA55AA_55AA55AA_55AA55AA_55AA55AA, 1'b0, 1'b0, -1);
    // R9: start while busy ignored
    runSeq(1'b1, 2'd0, 32'h0000_6000, 16'hF0F0,
           128'h00112233_44556677_8899AABB_CCDDEEFF, 1'b1, 1'b1, -1);
    // R10: abort in the cycle of the third response
    runSeq(1'b0, 2'd1, 32'h0000_7000, 16'hFFFF,
           128'h99999999_99999999_99999999_99999999, 1'b0, 1'b0, 2);
    // R7 R6: halfword load with stalls after abort
    runSeq(1'b0, 2'd1, 32'h0000_8006, 16'h3C03,
           128'h12345678_9ABCDEF0_0FEDCBA9_87654321, 1'b1, 1'b0, -1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule